// File: doc/BRIEF.md
# Indirect Byte-Port Register Accessor

This block turns one host register request into a timed access on a narrow parallel peripheral port. The host presents an address, a direction and, for writes, a data value. The block first places a truncated peripheral address on the port. It then raises a control word that carries the select strobe, the direction and, for writes, the data byte. It holds that word unchanged for a fixed number of clock cycles.

At the end of the hold, a read latches the low byte of the peripheral data bus. The control word then always drops back to zero, and a one-cycle completion pulse tells the host the access has finished. Only one access runs at a time. A request that arrives while an access is running is dropped and reported with a one-cycle error pulse.

Top module: `byte_port_accessor`

## Requirements
- R1: A synchronous active-high reset, applied at any time, drives `portAddr` to 0, `portCtrl` to 0, `busy`, `done` and `err` to 0, and `rdData` to 0 by the next clock edge.
- R2: In the cycle after an idle block accepts a request (`reqValid` high while `busy` is low), `portAddr` equals the low 18 bits of `reqAddr`, `portCtrl` is still 0, and `busy` is 1. The address therefore appears one cycle before the control word.
- R3: One cycle after the address appears, `portCtrl` takes its active value. Bit 8 is the strobe and is always 1. Bit 9 is 1 for a read. Bit 10 is 1 for a write. Bits 7:0 carry `reqData[7:0]` on a write and are 0 on a read.
- R4: The active control word stays constant for exactly `WAIT_CYCLES` cycles (default 20).
- R5: In the cycle right after the hold ends, `portCtrl` is 0, `done` is 1 for exactly one cycle, and `busy` is 0. After every access `portCtrl` is 0 whenever `busy` is 0.
- R6: A read sets `rdData` to `portDin[7:0]` zero-extended to 32 bits. The byte is sampled in the last cycle of the hold, and the new value is visible when `done` is 1.
- R7: A write leaves `rdData` unchanged. `rdData` changes only in a cycle in which `done` is 1.
- R8: `busy` is 1 from the cycle after acceptance up to the `done` cycle, and it falls only together with `done`.
- R9: A request made while `busy` is 1 is ignored. `err` is 1 for one cycle in the next cycle, and the running access keeps its address, control word and timing.
- R10: Address bits above bit 17 and data bits above bit 7 have no effect on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe, one cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Host address; low 18 bits used |
| reqData | input | 32 | Host write value; low byte used |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a request made while busy |
| rdData | output | 32 | Last read byte, zero-extended |
| portAddr | output | 18 | Peripheral address |
| portCtrl | output | 11 | Control word: [10] write, [9] read, [8] strobe, [7:0] write byte |
| portDin | input | 16 | Peripheral data bus; low byte used |

## Verification
The assertions assume that `reqValid` is a synchronous one-cycle pulse and that `portDin` is stable while the strobe is high. The bench model derives `portDin` combinationally from `portAddr`, so the bus is settled for the whole hold. The bench drives every request on the falling edge and releases it after one cycle. The only request made while busy is deliberate, and it is placed in the middle of the strobe hold.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

  localparam int CTRL_W     = 11;
  localparam int CTRL_WR    = 10;
  localparam int CTRL_RD    = 9;
  localparam int CTRL_STB   = 8;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_STROBE = 2'd2
  } accState_t;

  typedef struct packed {
    logic loadReq;
    logic driveCtrl;
    logic capture;
    logic clearCtrl;
  } dpCmd_t;

endpackage

// File: rtl/bpa_ctrl.sv
module bpa_ctrl
  import bpa_pkg::*;
#(
  parameter int WAIT_CYCLES = 20
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done,
  output logic   err
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  accState_t state;
  logic [CNT_W-1:0] holdCnt;
  logic holdEnd;

  assign busy    = (state != ST_IDLE);
  assign holdEnd = (state == ST_STROBE) && (holdCnt == CNT_LAST);

  always_comb begin
    cmd           = '0;
    cmd.loadReq   = (state == ST_IDLE) && reqValid;
    cmd.driveCtrl = (state == ST_ADDR);
    cmd.capture   = holdEnd;
    cmd.clearCtrl = holdEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= reqValid && busy;
      case (state)
        ST_IDLE: begin
          if (reqValid) state <= ST_ADDR;
        end
        ST_ADDR: begin
          state   <= ST_STROBE;
          holdCnt <= '0;
        end
        ST_STROBE: begin
          if (holdEnd) begin
            state   <= ST_IDLE;
            holdCnt <= '0;
            done    <= 1'b1;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: busy only drops together with done
  p_busy_until_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: err is only raised for a request seen while busy
  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(reqValid && busy));

  // R4: hold counter never passes its limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE) |-> (holdCnt <= CNT_LAST));

endmodule

// File: rtl/bpa_datapath.sv
module bpa_datapath
  import bpa_pkg::*;
#(
  parameter int REQ_ADDR_W  = 32,
  parameter int HOST_DATA_W = 32,
  parameter int PORT_ADDR_W = 18,
  parameter int PORT_DIN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpCmd_t                 cmd,
  input  logic                   reqWrite,
  input  logic [REQ_ADDR_W-1:0]  reqAddr,
  input  logic [HOST_DATA_W-1:0] reqData,
  input  logic [PORT_DIN_W-1:0]  portDin,
  output logic [PORT_ADDR_W-1:0] portAddr,
  output logic [CTRL_W-1:0]      portCtrl,
  output logic [HOST_DATA_W-1:0] rdData
);

  localparam int PAD_W = HOST_DATA_W - BYTE_W;

  logic              opWrite;
  logic [BYTE_W-1:0] opByte;
  logic [CTRL_W-1:0] activeCtrl;
  logic              unusedBits;

  assign unusedBits = ^{reqAddr[REQ_ADDR_W-1:PORT_ADDR_W],
                        reqData[HOST_DATA_W-1:BYTE_W],
                        portDin[PORT_DIN_W-1:BYTE_W]};

  always_comb begin
    activeCtrl           = '0;
    activeCtrl[CTRL_STB] = 1'b1;
    activeCtrl[CTRL_WR]  = opWrite;
    activeCtrl[CTRL_RD]  = !opWrite;
    activeCtrl[BYTE_W-1:0] = opWrite ? opByte : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      portAddr <= '0;
      portCtrl <= '0;
      rdData   <= '0;
      opWrite  <= 1'b0;
      opByte   <= '0;
    end else begin
      if (cmd.loadReq) begin
        portAddr <= reqAddr[PORT_ADDR_W-1:0];
        opWrite  <= reqWrite;
        opByte   <= reqData[BYTE_W-1:0];
      end
      if (cmd.driveCtrl) portCtrl <= activeCtrl;
      if (cmd.capture && !opWrite) rdData <= {{PAD_W{1'b0}}, portDin[BYTE_W-1:0]};
      if (cmd.clearCtrl) portCtrl <= '0;
    end
  end

  // R3: direction bits never both set
  p_dir_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(portCtrl[CTRL_WR:CTRL_RD]));

  // R3: a read control word carries no data byte
  p_rd_no_byte_r3: assert property (@(posedge clk) disable iff (rst)
    portCtrl[CTRL_RD] |-> (portCtrl[BYTE_W-1:0] == '0));

  // R6: read result always zero-extended
  p_zero_ext_r6: assert property (@(posedge clk) disable iff (rst)
    rdData[HOST_DATA_W-1:BYTE_W] == '0);

endmodule

// File: rtl/byte_port_accessor.sv
module byte_port_accessor
  import bpa_pkg::*;
#(
  parameter int WAIT_CYCLES = 20,
  parameter int REQ_ADDR_W  = 32,
  parameter int HOST_DATA_W = 32,
  parameter int PORT_ADDR_W = 18,
  parameter int PORT_DIN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [REQ_ADDR_W-1:0]  reqAddr,
  input  logic [HOST_DATA_W-1:0] reqData,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [HOST_DATA_W-1:0] rdData,
  output logic [PORT_ADDR_W-1:0] portAddr,
  output logic [CTRL_W-1:0]      portCtrl,
  input  logic [PORT_DIN_W-1:0]  portDin
);

  dpCmd_t cmd;

  bpa_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .cmd(cmd), .busy(busy), .done(done), .err(err)
  );

  bpa_datapath #(
    .REQ_ADDR_W(REQ_ADDR_W), .HOST_DATA_W(HOST_DATA_W),
    .PORT_ADDR_W(PORT_ADDR_W), .PORT_DIN_W(PORT_DIN_W)
  ) uData (
    .clk(clk), .rst(rst), .cmd(cmd), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .portDin(portDin),
    .portAddr(portAddr), .portCtrl(portCtrl), .rdData(rdData)
  );

  // R5: port control idle whenever no access runs
  p_idle_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (portCtrl == '0));

  // R2: address cycle precedes control word
  p_addr_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (portCtrl == '0));

  // R4: active control word does not move during the hold
  p_ctrl_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (portCtrl != '0) && ($past(portCtrl) != '0) |-> $stable(portCtrl));

  // R7: read result only moves on completion
  p_rd_moves_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdData) |-> done);

  // R9: address held while busy
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(portAddr));

endmodule

// File: tb/sim_byte_port_accessor.sv
module sim_byte_port_accessor;

  localparam int WAIT = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        busy, done, err;
  logic [31:0] rdData;
  logic [17:0] portAddr;
  logic [10:0] portCtrl;
  logic [15:0] portDin;

  logic [17:0] seenWrAddr = '0;
  logic [7:0]  seenWrByte = '0;
  logic [31:0] expRd = '0;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  // peripheral model: read byte derived from address, junk in upper byte
  assign portDin = {8'hC3, portAddr[7:0] ^ 8'h5A};
  always @(posedge clk) if (portCtrl[10] && portCtrl[8]) begin
    seenWrAddr <= portAddr;
    seenWrByte <= portCtrl[7:0];
  end

  byte_port_accessor #(.WAIT_CYCLES(WAIT)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .err(err), .rdData(rdData), .portAddr(portAddr), .portCtrl(portCtrl),
    .portDin(portDin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] ctrlOf(input logic wr, input logic [31:0] d);
    return wr ? {2'b10, 1'b1, d[7:0]} : {2'b01, 1'b1, 8'h00};
  endfunction

  task automatic runAccess(input logic wr, input logic [31:0] a, input logic [31:0] d);
    logic [10:0] ec;
    int n;
    ec = ctrlOf(wr, d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 addr", 32'(portAddr), 32'(a[17:0]));
    check("R2 ctrl idle", 32'(portCtrl), 32'h0);
    check("R8 busy", 32'(busy), 32'h1);
    @(negedge clk);
    check("R3 ctrl", 32'(portCtrl), 32'(ec));
    n = 0;
    while (portCtrl === ec && n < 200) begin
      n++;
      @(negedge clk);
    end
    check("R4 hold", n, WAIT);
    check("R5 ctrl cleared", 32'(portCtrl), 32'h0);
    check("R5 done", 32'(done), 32'h1);
    check("R8 busy low", 32'(busy), 32'h0);
    if (!wr) expRd = {24'h0, a[7:0] ^ 8'h5A};
    check(wr ? "R7 rd kept" : "R6 rd byte", rdData, expRd);
    if (wr) begin
      check("R3 wr byte", 32'(seenWrByte), 32'(d[7:0]));
      check("R10 wr addr", 32'(seenWrAddr), 32'(a[17:0]));
    end
    @(negedge clk);
    check("R5 done pulse", 32'(done), 32'h0);
  endtask

  localparam logic [64:0] VEC [6] = '{
    {1'b0, 32'h0000_0010, 32'h0000_0000},
    {1'b1, 32'h0000_0023, 32'h0000_00A5},
    {1'b0, 32'h0003_FFFF, 32'h0000_0000},
    {1'b1, 32'hFFFC_1234, 32'hDEAD_BE3C},
    {1'b0, 32'hABC0_0077, 32'h1234_5678},
    {1'b1, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addr", 32'(portAddr), 32'h0);
    check("R1 ctrl", 32'(portCtrl), 32'h0);
    check("R1 flags", {29'h0, busy, done, err}, 32'h0);
    check("R1 rd", rdData, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      runAccess(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);

    // R9: request while busy is dropped
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 32'h0000_0042;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 32'h0000_0099; reqData = 32'hFF;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 err pulse", 32'(err), 32'h1);
    check("R9 addr kept", 32'(portAddr), 32'h42);
    check("R9 ctrl kept", 32'(portCtrl), 32'(ctrlOf(1'b0, 32'h0)));
    @(negedge clk);
    check("R9 err single", 32'(err), 32'h0);
    while (!done) @(negedge clk);
    expRd = {24'h0, 8'h42 ^ 8'h5A};
    check("R9 read intact", rdData, expRd);

    // R1: reset in the middle of a write hold
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 32'h0000_0155; reqData = 32'h77;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid ctrl", 32'(portCtrl), 32'h0);
    check("R1 mid addr", 32'(portAddr), 32'h0);
    check("R1 mid busy", 32'(busy), 32'h0);
    check("R1 mid rd", rdData, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule